// File: doc/BRIEF.md
# Non-Preemptive Priority Channel Arbiter

This block decides which of five DMA channels owns a single shared bus master port. Each channel presents a request line and a 3-bit priority. The arbiter picks the requester with the highest effective priority. Once a channel holds the grant, it keeps it until the bus engine signals, with a one-cycle strobe, that the current burst or single transfer has finished. A higher-priority request that arrives during a transfer therefore waits for that completion boundary.

The grant is a registered one-hot vector together with the binary index of the owning channel. When the port is idle, a pending request is granted at the next clock edge. On the completion strobe, the arbiter makes a fresh decision from the requests present in that cycle. That decision may hand the port back to the same channel, move it to another channel, or release it. The bus protocol itself lies outside this block.

Top module: `chan_bus_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `grant_onehot` is 0 and `grant_chan` is 0. A reset during an active grant clears that grant.
- R2: `grant_onehot` has at most one bit set. When bit i is set, `grant_chan` equals i. When no bit is set, `grant_chan` is 0.
- R3: When no channel holds the grant and at least one request is high at a rising edge, a grant is visible after that same edge.
- R4: The grant goes to the requesting channel with the largest effective priority. Priority 5 is the highest and 0 the lowest.
- R5: Among requesters that share the largest effective priority, the channel with the lowest index wins.
- R6: Priority codes 6 and 7 are handled exactly as 5.
- R7: While a channel holds the grant and `xfer_done` is low, the grant does not change. This holds when a higher-priority channel raises a request and when the owner drops its own request.
- R8: At an edge where `xfer_done` is high, the next grant is chosen by R4 to R6 from the requests present at that edge. The channel that just finished may be chosen again.
- R9: If no request is high at an edge where the port is idle, or at an edge where `xfer_done` is high, the grant becomes all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ch_req | input | 5 | Request per channel, bit i for channel i |
| ch_prio | input | 15 | Priority per channel, bits [3i+2:3i] for channel i |
| xfer_done | input | 1 | One-cycle strobe: current burst or single transfer finished |
| grant_onehot | output | 5 | Registered one-hot grant, all zero when idle |
| grant_chan | output | 3 | Index of the granted channel, 0 when idle |

## Verification
The grant is a single register stage, so every decision lands one edge after the inputs it was made from. This applies to a request reaching an idle port, to a completion strobe, and to reset. The bench drives inputs a little after a rising edge and reads the outputs a little after the following rising edge. Each expected value is therefore compared exactly one edge after its stimulus. The hold checks read the outputs at every edge of a multi-cycle window, to show that nothing moves before the strobe.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int unsigned DEF_NUM_CH   = 5;
    localparam int unsigned DEF_PRIO_W   = 3;
    localparam int unsigned DEF_PRIO_MAX = 5;

    typedef enum logic {
        HOLD_IDLE = 1'b0,
        HOLD_BUSY = 1'b1
    } hold_st_e;

    // Saturate a priority code at the top legal level.
    function automatic logic [7:0] clamp_prio(input logic [7:0] raw,
                                              input logic [7:0] top);
        return (raw > top) ? top : raw;
    endfunction

endpackage

// File: rtl/prio_clamp.sv
module prio_clamp #(
    parameter int unsigned NUM_CH   = arb_pkg::DEF_NUM_CH,
    parameter int unsigned PRIO_W   = arb_pkg::DEF_PRIO_W,
    parameter int unsigned PRIO_MAX = arb_pkg::DEF_PRIO_MAX
) (
    input  logic [NUM_CH*PRIO_W-1:0] raw_prio,
    output logic [NUM_CH*PRIO_W-1:0] eff_prio
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb begin
            eff_prio[g*PRIO_W +: PRIO_W] =
                PRIO_W'(arb_pkg::clamp_prio(8'(raw_prio[g*PRIO_W +: PRIO_W]),
                                            8'(PRIO_MAX)));
        end
    end
endmodule

// File: rtl/winner_pick.sv
module winner_pick #(
    parameter int unsigned NUM_CH = arb_pkg::DEF_NUM_CH,
    parameter int unsigned PRIO_W = arb_pkg::DEF_PRIO_W,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] eff_prio,
    output logic                     any_req,
    output logic [IDX_W-1:0]         win_idx
);
    logic [PRIO_W-1:0] best_p;

    // Scan upward; only a strictly larger priority replaces the
    // current pick, so ties stay with the lower index.
    always_comb begin
        any_req = 1'b0;
        best_p  = '0;
        win_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && (!any_req || eff_prio[i*PRIO_W +: PRIO_W] > best_p)) begin
                any_req = 1'b1;
                best_p  = eff_prio[i*PRIO_W +: PRIO_W];
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/grant_hold.sv
module grant_hold #(
    parameter int unsigned NUM_CH = arb_pkg::DEF_NUM_CH,
    parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_req,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] grant_onehot,
    output logic [IDX_W-1:0]  grant_chan
);
    import arb_pkg::*;

    hold_st_e         st_q;
    logic [IDX_W-1:0] own_q;
    logic             boundary;

    // A decision is taken only at a transfer boundary or while idle.
    assign boundary = (st_q == HOLD_IDLE) || xfer_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HOLD_IDLE;
            own_q <= '0;
        end else if (boundary) begin
            if (any_req) begin
                st_q  <= HOLD_BUSY;
                own_q <= win_idx;
            end else begin
                st_q  <= HOLD_IDLE;
                own_q <= '0;
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign grant_onehot[g] = (st_q == HOLD_BUSY) && (own_q == IDX_W'(g));
    end

    assign grant_chan = own_q;
endmodule

// File: rtl/chan_bus_arbiter.sv
module chan_bus_arbiter #(
    parameter int unsigned NUM_CH   = arb_pkg::DEF_NUM_CH,
    parameter int unsigned PRIO_W   = arb_pkg::DEF_PRIO_W,
    parameter int unsigned PRIO_MAX = arb_pkg::DEF_PRIO_MAX,
    localparam int unsigned IDX_W   = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic                     xfer_done,
    output logic [NUM_CH-1:0]        grant_onehot,
    output logic [IDX_W-1:0]         grant_chan
);
    logic [NUM_CH*PRIO_W-1:0] eff_prio;
    logic                     any_req;
    logic [IDX_W-1:0]         win_idx;

    prio_clamp #(
        .NUM_CH   (NUM_CH),
        .PRIO_W   (PRIO_W),
        .PRIO_MAX (PRIO_MAX)
    ) u_clamp (
        .raw_prio (ch_prio),
        .eff_prio (eff_prio)
    );

    winner_pick #(
        .NUM_CH (NUM_CH),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .req      (ch_req),
        .eff_prio (eff_prio),
        .any_req  (any_req),
        .win_idx  (win_idx)
    );

    grant_hold #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_hold (
        .clk          (clk),
        .rst          (rst),
        .any_req      (any_req),
        .win_idx      (win_idx),
        .xfer_done    (xfer_done),
        .grant_onehot (grant_onehot),
        .grant_chan   (grant_chan)
    );
endmodule

// File: rtl/chan_bus_arbiter_chk.sv
module chan_bus_arbiter_chk #(
    parameter int unsigned NUM_CH = 5,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_req,
    input logic              xfer_done,
    input logic [NUM_CH-1:0] grant_onehot,
    input logic [IDX_W-1:0]  grant_chan
);
    // R2
    onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_onehot));

    // R2
    index_match_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant_onehot) |-> grant_onehot[grant_chan]);

    // R2
    idle_index_chk: assert property (@(posedge clk) disable iff (rst)
        !(|grant_onehot) |-> (grant_chan == '0));

    // R7
    hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
        ((|grant_onehot) && !xfer_done) |=> $stable(grant_onehot));

    // R3
    idle_serve_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|grant_onehot) && (|ch_req)) |=> (|grant_onehot));

    // R8
    grant_was_req_chk: assert property (@(posedge clk) disable iff (rst)
        ((!(|grant_onehot) || xfer_done) && (|ch_req))
            |=> ((grant_onehot & $past(ch_req)) != '0));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        ((!(|grant_onehot) || xfer_done) && (ch_req == '0))
            |=> (grant_onehot == '0));
endmodule

bind chan_bus_arbiter chan_bus_arbiter_chk #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ch_req       (ch_req),
    .xfer_done    (xfer_done),
    .grant_onehot (grant_onehot),
    .grant_chan   (grant_chan)
);

// File: tb/test_chan_bus_arbiter.sv
`timescale 1ns/1ps
module test_chan_bus_arbiter;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  ch_req;
    logic [14:0] ch_prio;
    logic        xfer_done;
    logic [4:0]  grant_onehot;
    logic [2:0]  grant_chan;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chan_bus_arbiter i_chan_bus_arbiter (
        .clk          (clk),
        .rst          (rst),
        .ch_req       (ch_req),
        .ch_prio      (ch_prio),
        .xfer_done    (xfer_done),
        .grant_onehot (grant_onehot),
        .grant_chan   (grant_chan)
    );

    // Each entry: {request[4:0], priorities {p4,p3,p2,p1,p0}, expected grant[4:0]}
    localparam logic [24:0] VEC [8] = '{
        {5'b00001, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 5'b00001}, // R3 single requester
        {5'b11111, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 5'b10000}, // R4 top priority
        {5'b10110, 3'd2, 3'd0, 3'd4, 3'd4, 3'd0, 5'b00010}, // R5 tie, lower index
        {5'b01010, 3'd0, 3'd7, 3'd0, 3'd5, 3'd0, 5'b00010}, // R6 7 counts as 5
        {5'b01100, 3'd0, 3'd5, 3'd6, 3'd0, 3'd0, 5'b00100}, // R6 6 counts as 5
        {5'b10001, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 5'b10000}, // R4 low vs lowest
        {5'b00000, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 5'b00000}, // R9 nothing asked
        {5'b11111, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 5'b00001}  // R5 all equal
    };

    function automatic logic [2:0] idx_of(input logic [4:0] oh);
        for (int i = 0; i < 5; i++) if (oh[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [4:0] exp);
        total++;
        if (grant_onehot !== exp || grant_chan !== idx_of(exp)) begin
            bad++;
            $display("FAIL %s: grant=%b chan=%0d expected grant=%b chan=%0d",
                     tag, grant_onehot, grant_chan, exp, idx_of(exp));
        end
    endtask

    function automatic logic [14:0] prios(input logic [2:0] p4, p3, p2, p1, p0);
        return {p4, p3, p2, p1, p0};
    endfunction

    initial begin
        rst = 1'b1; ch_req = '0; ch_prio = '0; xfer_done = 1'b0;
        step(); step();
        check("R1 in reset", 5'b00000);
        rst = 1'b0;
        step();
        check("R1 after release", 5'b00000);

        // Vector table: each starts from idle and is released afterwards.
        for (int v = 0; v < 8; v++) begin
            ch_req    = VEC[v][24:20];
            ch_prio   = VEC[v][19:5];
            xfer_done = 1'b0;
            step();
            check($sformatf("R3/R4/R5/R6/R9 vector %0d", v), VEC[v][4:0]);
            ch_req    = '0;
            xfer_done = 1'b1;
            step();
            check($sformatf("R9 release after vector %0d", v), 5'b00000);
            xfer_done = 1'b0;
        end

        // R7: grant held across a higher-priority arrival.
        ch_prio = prios(3'd5, 3'd0, 3'd0, 3'd0, 3'd1);
        ch_req  = 5'b00001;
        step();
        check("R3 ch0 granted", 5'b00001);
        ch_req = 5'b10001;
        for (int c = 0; c < 3; c++) begin
            step();
            check("R7 hold against higher arrival", 5'b00001);
        end
        ch_req = 5'b10000;
        step();
        check("R7 hold after owner drops request", 5'b00001);

        // R8: switch at the boundary.
        xfer_done = 1'b1;
        step();
        check("R8 switch at boundary", 5'b10000);
        // R8: same channel re-granted.
        step();
        check("R8 owner re-granted", 5'b10000);
        // R8: clamped tie at boundary goes to the lower index.
        ch_prio = prios(3'd5, 3'd0, 3'd7, 3'd0, 3'd0);
        ch_req  = 5'b10100;
        step();
        check("R8 boundary tie lower index", 5'b00100);
        // R9: release at boundary.
        ch_req = '0;
        step();
        check("R9 release at boundary", 5'b00000);
        xfer_done = 1'b0;

        // R1: reset clears an active grant.
        ch_req = 5'b01000;
        step();
        check("R3 ch3 granted", 5'b01000);
        rst = 1'b1;
        step();
        check("R1 reset clears grant", 5'b00000);
        rst = 1'b0; ch_req = '0;
        step();
        check("R1 idle after reset", 5'b00000);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: state=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule